// File: doc/BRIEF.md
# Two-Way Set-Associative Cache Controller

This block sits between a processor-side word port and a main memory that moves one word per handshake beat. Every word address is cut into three fields: a tag in the upper bits, a set index in the middle and a word-within-block offset in the low bits. The indexed set holds two lines, and both stored tags are compared in parallel on every reference. A read hit is answered in the same cycle as the request. A read miss loads the whole block into a line of the set. When the early-forward option is on, the requested word goes to the processor in the same beat that it comes in from memory.

Writes follow two independent policy inputs. One picks write-through or write-back. The other picks whether a write miss fetches the block first or goes straight to memory without touching the cache. A separate command port can invalidate a line. It can also pin a line to write-through behaviour while the global policy is write-back. Each set has a single replacement bit. A dirty victim is written out in full before its replacement is fetched.

Top module: `assoc2_cache_ctrl`

## Requirements
- R1: The 32-bit word address splits into tag (upper bits), set (SET_W bits) and word offset (WORD_W = 5 low bits). With SET_W = 13 the tag is 14 bits. The default SET_W = 4 keeps the store small. Memory beats for a line use address {tag, set, beat}.
- R2: After reset every line is invalid, mem_req is low and cpu_ready is low.
- R3: A read that hits raises cpu_ready in the first cycle of the request, with the stored word on cpu_rdata, and makes no memory beat.
- R4: A read miss fetches all 32 words of the addressed block into the chosen line. The read beats start at word 0 and ascend.
- R5: With cfg_load_through high, a read miss on word k raises cpu_ready in the cycle of read beat k+1 and carries that beat's data, so word 31 gains nothing. With it low, ready comes after all 32 beats.
- R6: On a miss the victim is way 0 if invalid, else way 1 if invalid, else the way named by the set's replacement bit. After each hit served or fill completed, that bit names the other way.
- R7: A victim that is valid and dirty is written to memory in 32 write beats before any read beat of the new block.
- R8: With cfg_write_back low, a write hit updates the line and makes exactly one memory write of cpu_wdata to cpu_addr. cpu_ready rises in the cycle that beat is accepted.
- R9: With cfg_write_back high, a write hit on a line not pinned to write-through updates only the line, marks it dirty, raises cpu_ready at once and makes no memory beat.
- R10: A write miss with cfg_write_alloc high fetches the block and then completes as a write hit. With cfg_write_alloc low it makes one memory write and leaves the cache unchanged, so a later read of that address misses.
- R11: Command op 1 on a valid matching line pins it to write-through. Writes to it then reach memory even under write-back. A refill clears the pin.
- R12: Command op 0 on a valid matching line makes it invalid and drops any dirty data. A command that matches no line has no effect.
- R13: A command is applied in a cycle where the controller is idle. A processor request in the same cycle is not served in that cycle and is handled afterwards.
- R14: Memory handshake: mem_req stays high with mem_addr, mem_we and mem_wdata stable until mem_ready. A beat completes when both are high, and mem_rdata is taken in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_write_back | input | 1 | 1 = write-back, 0 = write-through |
| cfg_write_alloc | input | 1 | 1 = fetch the block on a write miss |
| cfg_load_through | input | 1 | 1 = forward the missed word during the fill |
| cmd_valid | input | 1 | Line command strobe |
| cmd_op | input | 1 | 0 = invalidate, 1 = pin to write-through |
| cmd_addr | input | 32 | Address that selects the line for the command |
| cpu_req | input | 1 | Request, held until cpu_ready |
| cpu_we | input | 1 | 1 = write |
| cpu_addr | input | 32 | Word address |
| cpu_wdata | input | 32 | Write data |
| cpu_ready | output | 1 | Request complete this cycle |
| cpu_rdata | output | 32 | Read data, valid with cpu_ready |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | 1 = memory write beat |
| mem_addr | output | 32 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_ready | input | 1 | Memory accepts or delivers the beat |
| mem_rdata | input | 32 | Memory read data |

## Verification
A line command and a processor request can arrive in the same idle cycle. The bench raises both together, with an invalidate aimed at the very line the read would hit. It then checks that cpu_ready stays low in that cycle. It also checks that the read is served as a full miss: 32 read beats and the data memory holds. The other overlap is the early-forwarded word: it reaches the processor in the same cycle its beat is written into the line. This is judged by comparing the read-beat count at the moment cpu_ready rises with the word offset, and by a later hit to that word returning the same data.

// File: rtl/c2_pkg.sv
package c2_pkg;
    localparam int C2_WAYS = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WTWR  = 2'd1,
        ST_EVICT = 2'd2,
        ST_FILL  = 2'd3
    } c2_state_e;
endpackage

// File: rtl/c2_tag_cmp.sv
module c2_tag_cmp
    import c2_pkg::*;
#(
    parameter int TAG_W = 23
) (
    input  logic [TAG_W-1:0]                 tag_i,
    input  logic [C2_WAYS-1:0][TAG_W-1:0]    way_tag_i,
    input  logic [C2_WAYS-1:0]               way_vld_i,
    output logic                             hit_o,
    output logic                             hit_way_o
);
    logic [C2_WAYS-1:0] match;

    for (genvar w = 0; w < C2_WAYS; w++) begin : g_way
        assign match[w] = way_vld_i[w] && (way_tag_i[w] == tag_i);
    end

    assign hit_o     = |match;
    assign hit_way_o = match[1];
endmodule

// File: rtl/c2_victim_pick.sv
module c2_victim_pick (
    input  logic [1:0] vld_i,
    input  logic       lru_i,
    output logic       way_o
);
    always_comb begin
        if (!vld_i[0])      way_o = 1'b0;
        else if (!vld_i[1]) way_o = 1'b1;
        else                way_o = lru_i;
    end
endmodule

// File: rtl/c2_data_store.sv
module c2_data_store #(
    parameter int DATA_W = 32,
    parameter int SET_W  = 4,
    parameter int WORD_W = 5
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic              wway_i,
    input  logic [SET_W-1:0]  wset_i,
    input  logic [WORD_W-1:0] wword_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              rway_i,
    input  logic [SET_W-1:0]  rset_i,
    input  logic [WORD_W-1:0] rword_i,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int IDX_W = 1 + SET_W + WORD_W;
    localparam int DEPTH = 1 << IDX_W;

    logic [DATA_W-1:0] store_q [DEPTH];
    logic [IDX_W-1:0]  widx;
    logic [IDX_W-1:0]  ridx;

    assign widx    = {wway_i, wset_i, wword_i};
    assign ridx    = {rway_i, rset_i, rword_i};
    assign rdata_o = store_q[ridx];

    always_ff @(posedge clk) begin
        if (we_i) store_q[widx] <= wdata_i;
    end
endmodule

// File: rtl/assoc2_cache_ctrl.sv
module assoc2_cache_ctrl
    import c2_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int SET_W  = 4,
    parameter int WORD_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_write_back,
    input  logic              cfg_write_alloc,
    input  logic              cfg_load_through,
    input  logic              cmd_valid,
    input  logic              cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ready,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int TAG_W = ADDR_W - SET_W - WORD_W;
    localparam int SETS  = 1 << SET_W;
    localparam logic [WORD_W-1:0] LAST_BEAT = '1;

    typedef struct packed {
        c2_state_e         st;
        logic [WORD_W-1:0] beat;
        logic              way;
        logic              hit;
        logic              we;
        logic [TAG_W-1:0]  tag;
        logic [SET_W-1:0]  set;
        logic [WORD_W-1:0] word;
        logic [DATA_W-1:0] wdata;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    // line bookkeeping per way and set
    logic [TAG_W-1:0] tag_q   [C2_WAYS][SETS];
    logic [SETS-1:0]  vld_q   [C2_WAYS];
    logic [SETS-1:0]  dirty_q [C2_WAYS];
    logic [SETS-1:0]  wtf_q   [C2_WAYS];
    logic [SETS-1:0]  lru_q;

    // lookup path, shared by commands and requests while idle
    logic [ADDR_W-1:0]               lk_addr;
    logic [TAG_W-1:0]                lk_tag;
    logic [SET_W-1:0]                lk_set;
    logic [WORD_W-1:0]               lk_word;
    logic [C2_WAYS-1:0][TAG_W-1:0]   lk_way_tag;
    logic [C2_WAYS-1:0]              lk_way_vld;
    logic                            lk_hit;
    logic                            hit_way;
    logic                            victim;
    logic                            wt_eff;

    // store ports
    logic              ds_we;
    logic              ds_wway;
    logic [SET_W-1:0]  ds_wset;
    logic [WORD_W-1:0] ds_wword;
    logic [DATA_W-1:0] ds_wdata;
    logic              ds_rway;
    logic [SET_W-1:0]  ds_rset;
    logic [WORD_W-1:0] ds_rword;
    logic [DATA_W-1:0] ds_rdata;

    // bookkeeping updates
    logic              fill_en, touch_en, dirty_en, inv_en, wtf_en;
    logic              t_way;
    logic [SET_W-1:0]  t_set;

    assign lk_addr = cmd_valid ? cmd_addr : cpu_addr;
    assign lk_tag  = lk_addr[ADDR_W-1 -: TAG_W];
    assign lk_set  = lk_addr[WORD_W +: SET_W];
    assign lk_word = lk_addr[WORD_W-1:0];

    always_comb begin
        for (int w = 0; w < C2_WAYS; w++) begin
            lk_way_tag[w] = tag_q[w][lk_set];
            lk_way_vld[w] = vld_q[w][lk_set];
        end
    end

    c2_tag_cmp #(.TAG_W(TAG_W)) u_cmp (
        .tag_i     (lk_tag),
        .way_tag_i (lk_way_tag),
        .way_vld_i (lk_way_vld),
        .hit_o     (lk_hit),
        .hit_way_o (hit_way)
    );

    c2_victim_pick u_vic (
        .vld_i (lk_way_vld),
        .lru_i (lru_q[lk_set]),
        .way_o (victim)
    );

    assign wt_eff = !cfg_write_back || wtf_q[hit_way][lk_set];

    assign ds_rway  = (ctl_q.st == ST_EVICT) ? ctl_q.way  : hit_way;
    assign ds_rset  = (ctl_q.st == ST_EVICT) ? ctl_q.set  : lk_set;
    assign ds_rword = (ctl_q.st == ST_EVICT) ? ctl_q.beat : lk_word;

    c2_data_store #(.DATA_W(DATA_W), .SET_W(SET_W), .WORD_W(WORD_W)) u_store (
        .clk     (clk),
        .we_i    (ds_we),
        .wway_i  (ds_wway),
        .wset_i  (ds_wset),
        .wword_i (ds_wword),
        .wdata_i (ds_wdata),
        .rway_i  (ds_rway),
        .rset_i  (ds_rset),
        .rword_i (ds_rword),
        .rdata_o (ds_rdata)
    );

    assign t_way     = (ctl_q.st == ST_IDLE) ? hit_way : ctl_q.way;
    assign t_set     = (ctl_q.st == ST_IDLE) ? lk_set  : ctl_q.set;
    assign cpu_rdata = (ctl_q.st == ST_FILL) ? mem_rdata : ds_rdata;

    always_comb begin
        ctl_d     = ctl_q;
        cpu_ready = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        ds_we     = 1'b0;
        ds_wway   = ctl_q.way;
        ds_wset   = ctl_q.set;
        ds_wword  = ctl_q.beat;
        ds_wdata  = mem_rdata;
        fill_en   = 1'b0;
        touch_en  = 1'b0;
        dirty_en  = 1'b0;
        inv_en    = 1'b0;
        wtf_en    = 1'b0;

        unique case (ctl_q.st)
            ST_IDLE: begin
                if (cmd_valid) begin
                    // command wins the idle cycle; a request waits
                    if (lk_hit) begin
                        inv_en = !cmd_op;
                        wtf_en = cmd_op;
                    end
                end else if (cpu_req) begin
                    ctl_d.tag   = lk_tag;
                    ctl_d.set   = lk_set;
                    ctl_d.word  = lk_word;
                    ctl_d.we    = cpu_we;
                    ctl_d.wdata = cpu_wdata;
                    ctl_d.beat  = '0;
                    if (lk_hit) begin
                        ctl_d.way = hit_way;
                        ctl_d.hit = 1'b1;
                        if (!cpu_we) begin
                            cpu_ready = 1'b1;
                            touch_en  = 1'b1;
                        end else if (wt_eff) begin
                            ctl_d.st = ST_WTWR;
                        end else begin
                            cpu_ready = 1'b1;
                            touch_en  = 1'b1;
                            dirty_en  = 1'b1;
                            ds_we     = 1'b1;
                            ds_wway   = hit_way;
                            ds_wset   = lk_set;
                            ds_wword  = lk_word;
                            ds_wdata  = cpu_wdata;
                        end
                    end else if (cpu_we && !cfg_write_alloc) begin
                        ctl_d.hit = 1'b0;
                        ctl_d.st  = ST_WTWR;
                    end else begin
                        ctl_d.hit = 1'b0;
                        ctl_d.way = victim;
                        ctl_d.st  = (vld_q[victim][lk_set] && dirty_q[victim][lk_set])
                                    ? ST_EVICT : ST_FILL;
                    end
                end
            end

            ST_WTWR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {ctl_q.tag, ctl_q.set, ctl_q.word};
                mem_wdata = ctl_q.wdata;
                if (mem_ready) begin
                    cpu_ready = 1'b1;
                    ctl_d.st  = ST_IDLE;
                    if (ctl_q.hit) begin
                        ds_we    = 1'b1;
                        ds_wword = ctl_q.word;
                        ds_wdata = ctl_q.wdata;
                        touch_en = 1'b1;
                    end
                end
            end

            ST_EVICT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {tag_q[ctl_q.way][ctl_q.set], ctl_q.set, ctl_q.beat};
                mem_wdata = ds_rdata;
                if (mem_ready) begin
                    ctl_d.beat = ctl_q.beat + 1'b1;
                    if (ctl_q.beat == LAST_BEAT) ctl_d.st = ST_FILL;
                end
            end

            ST_FILL: begin
                mem_req  = 1'b1;
                mem_addr = {ctl_q.tag, ctl_q.set, ctl_q.beat};
                if (mem_ready) begin
                    ds_we      = 1'b1;
                    ctl_d.beat = ctl_q.beat + 1'b1;
                    if (cfg_load_through && !ctl_q.we && (ctl_q.beat == ctl_q.word))
                        cpu_ready = 1'b1;
                    if (ctl_q.beat == LAST_BEAT) begin
                        fill_en  = 1'b1;
                        touch_en = 1'b1;
                        ctl_d.st = ST_IDLE;
                    end
                end
            end

            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int w = 0; w < C2_WAYS; w++) begin
                vld_q[w]   <= '0;
                dirty_q[w] <= '0;
                wtf_q[w]   <= '0;
                for (int s = 0; s < SETS; s++) tag_q[w][s] <= '0;
            end
            lru_q <= '0;
        end else begin
            if (fill_en) begin
                tag_q[ctl_q.way][ctl_q.set]   <= ctl_q.tag;
                vld_q[ctl_q.way][ctl_q.set]   <= 1'b1;
                dirty_q[ctl_q.way][ctl_q.set] <= 1'b0;
                wtf_q[ctl_q.way][ctl_q.set]   <= 1'b0;
            end
            if (dirty_en) dirty_q[hit_way][lk_set] <= 1'b1;
            if (inv_en) begin
                vld_q[hit_way][lk_set]   <= 1'b0;
                dirty_q[hit_way][lk_set] <= 1'b0;
                wtf_q[hit_way][lk_set]   <= 1'b0;
            end
            if (wtf_en)   wtf_q[hit_way][lk_set] <= 1'b1;
            if (touch_en) lru_q[t_set] <= ~t_way;
        end
    end
endmodule

// File: rtl/assoc2_cache_ctrl_chk.sv
module assoc2_cache_ctrl_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int WORD_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req,
    input logic              cpu_we,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic [DATA_W-1:0] cpu_wdata,
    input logic              cpu_ready,
    input logic [DATA_W-1:0] cpu_rdata,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_ready,
    input logic [DATA_W-1:0] mem_rdata
);
    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R14

    AST_FILL_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_ready && !mem_we && (mem_addr[WORD_W-1:0] != '1)
        |=> mem_req && !mem_we && (mem_addr == $past(mem_addr) + 1'b1)); // R4

    AST_READY_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> cpu_req); // R3

    AST_EARLY_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready && mem_req && !mem_we |-> mem_ready && !cpu_we && (cpu_rdata == mem_rdata)); // R5

    AST_WT_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready && mem_req && mem_we
        |-> mem_ready && cpu_we && (mem_wdata == cpu_wdata) && (mem_addr == cpu_addr)); // R8
endmodule

bind assoc2_cache_ctrl assoc2_cache_ctrl_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .WORD_W (WORD_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_req   (cpu_req),
    .cpu_we    (cpu_we),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .cpu_ready (cpu_ready),
    .cpu_rdata (cpu_rdata),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ready (mem_ready),
    .mem_rdata (mem_rdata)
);

// File: tb/tb_assoc2_cache_ctrl.sv
module tb_assoc2_cache_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int SET_W  = 4;
    localparam int WORD_W = 5;
    localparam int TAG_W  = 32 - SET_W - WORD_W;
    localparam int SETS   = 1 << SET_W;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_write_back = 1'b1, cfg_write_alloc = 1'b1, cfg_load_through = 1'b1;
    logic        cmd_valid = 1'b0, cmd_op = 1'b0;
    logic [31:0] cmd_addr = '0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0;
    logic        cpu_ready;
    logic [31:0] cpu_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ready = 1'b0;
    logic [31:0] mem_rdata = '0;

    int total = 0;
    int bad = 0;
    int rd_beats = 0;
    int wr_beats = 0;
    logic [31:0] first_rd_addr = '0;

    logic [31:0] memv [logic [31:0]];
    logic [31:0] gold [logic [31:0]];

    bit               m_vld   [2][SETS];
    bit               m_dirty [2][SETS];
    bit               m_wtf   [2][SETS];
    logic [TAG_W-1:0] m_tag   [2][SETS];
    bit               m_lru   [SETS];

    always #(CLK_PERIOD/2) clk = ~clk;

    assoc2_cache_ctrl #(.SET_W(SET_W), .WORD_W(WORD_W)) dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_write_back(cfg_write_back), .cfg_write_alloc(cfg_write_alloc),
        .cfg_load_through(cfg_load_through),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata)
    );

    function automatic logic [31:0] init_val(logic [31:0] a);
        return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
    endfunction

    function automatic logic [31:0] mem_rd(logic [31:0] a);
        return memv.exists(a) ? memv[a] : init_val(a);
    endfunction

    function automatic logic [31:0] gold_rd(logic [31:0] a);
        return gold.exists(a) ? gold[a] : init_val(a);
    endfunction

    function automatic logic [31:0] mk(int tg, int st, int wd);
        return {tg[TAG_W-1:0], st[SET_W-1:0], wd[WORD_W-1:0]};
    endfunction

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%0h exp=%0h", rq, what, act, exp);
        end
    endtask

    // memory model: beat decided at negedge, taken at the following posedge
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ready = 1'b0;
        end else begin
            mem_ready = (($urandom % 4) != 0);
            if (mem_req) mem_rdata = mem_rd(mem_addr);
            if (mem_req && mem_ready) begin
                if (mem_we) begin
                    memv[mem_addr] = mem_wdata;
                    wr_beats++;
                end else begin
                    if (rd_beats == 0) first_rd_addr = mem_addr;
                    rd_beats++;
                end
            end
        end
    end

    function automatic int find_way(logic [31:0] a);
        logic [SET_W-1:0] s = a[WORD_W +: SET_W];
        logic [TAG_W-1:0] t = a[31 -: TAG_W];
        for (int w = 0; w < 2; w++) if (m_vld[w][s] && m_tag[w][s] == t) return w;
        return -1;
    endfunction

    task automatic model_cmd(input bit op, input logic [31:0] a);
        int w = find_way(a);
        logic [SET_W-1:0] s = a[WORD_W +: SET_W];
        if (w < 0) return;
        if (!op) begin
            if (m_dirty[w][s]) begin
                for (int k = 0; k < 32; k++) begin
                    logic [31:0] ba = {m_tag[w][s], s, k[WORD_W-1:0]};
                    gold[ba] = mem_rd(ba);
                end
            end
            m_vld[w][s] = 0; m_dirty[w][s] = 0; m_wtf[w][s] = 0;
        end else begin
            m_wtf[w][s] = 1;
        end
    endtask

    task automatic do_cmd(input bit op, input logic [31:0] a);
        model_cmd(op, a);
        @(negedge clk); #1;
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = a;
        @(negedge clk); #1;
        cmd_valid = 1'b0;
    endtask

    task automatic run_op(input bit we, input logic [31:0] a, input logic [31:0] d,
                          input bit with_cmd, input bit cop);
        logic [SET_W-1:0] s = a[WORD_W +: SET_W];
        logic [TAG_W-1:0] t = a[31 -: TAG_W];
        int word = int'(a[WORD_W-1:0]);
        int w, v, exp_rd, exp_wr, exp_at, lat, rd_at;
        bit hit, ev, wt, lat0_exp;
        logic [31:0] got, exp_data;

        if (with_cmd) model_cmd(cop, a);
        w = find_way(a);
        hit = (w >= 0);
        exp_rd = 0; exp_wr = 0; exp_at = -1; lat0_exp = 0; wt = 0;
        exp_data = gold_rd(a);
        if (hit) begin
            if (we) begin
                wt = !cfg_write_back || m_wtf[w][s];
                exp_wr = wt ? 1 : 0;
                lat0_exp = !wt;
                if (!wt) m_dirty[w][s] = 1;
            end else begin
                lat0_exp = 1;
            end
            m_lru[s] = !w[0];
        end else if (we && !cfg_write_alloc) begin
            exp_wr = 1;
            wt = 1;
        end else begin
            v = !m_vld[0][s] ? 0 : (!m_vld[1][s] ? 1 : int'(m_lru[s]));
            ev = m_vld[v][s] && m_dirty[v][s];
            exp_wr = ev ? 32 : 0;
            exp_rd = 32;
            m_vld[v][s] = 1; m_tag[v][s] = t; m_dirty[v][s] = 0; m_wtf[v][s] = 0;
            m_lru[s] = !v[0];
            if (!we) exp_at = cfg_load_through ? word + 1 : 32;
            else begin
                wt = !cfg_write_back;
                exp_wr += wt ? 1 : 0;
                if (!wt) m_dirty[v][s] = 1;
            end
        end
        if (we) gold[a] = d;

        rd_beats = 0; wr_beats = 0;
        @(negedge clk); #1;
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
        if (with_cmd) begin cmd_valid = 1'b1; cmd_op = cop; cmd_addr = a; end
        lat = 0;
        forever begin
            #1;
            if (with_cmd && lat == 0)
                chk(cpu_ready == 1'b0, "R13", "ready during command cycle", cpu_ready, 0);
            else if (cpu_ready) break;
            lat++;
            @(negedge clk); #1;
            cmd_valid = 1'b0;
        end
        got = cpu_rdata;
        rd_at = rd_beats;
        @(negedge clk); #1;
        cpu_req = 1'b0; cpu_we = 1'b0;
        while (mem_req) @(negedge clk);

        if (!we) chk(got == exp_data, hit ? "R3" : "R4", "read data", got, exp_data);
        if (lat0_exp) chk(lat == 0, we ? "R9" : "R3", "hit latency", lat, 0);
        if (exp_at > 0)
            chk(rd_at == exp_at, "R5", "read beats when ready", rd_at, exp_at);
        chk(rd_beats == exp_rd, hit ? "R6" : "R4", "read beats", rd_beats, exp_rd);
        chk(wr_beats == exp_wr, "R7", "write beats", wr_beats, exp_wr);
        if (exp_rd > 0)
            chk(first_rd_addr == {a[31:WORD_W], {WORD_W{1'b0}}}, "R1", "first fill address",
                first_rd_addr, {a[31:WORD_W], {WORD_W{1'b0}}});
        if (wt) chk(mem_rd(a) == d, we && hit ? "R8" : "R10", "memory word after write", mem_rd(a), d);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL R14 watchdog act=hung exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] a;
        void'($urandom(7));
        repeat (3) @(negedge clk);
        #1;
        // R2: reset state
        chk(mem_req == 1'b0, "R2", "mem_req in reset", mem_req, 0);
        chk(cpu_ready == 1'b0, "R2", "cpu_ready in reset", cpu_ready, 0);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk(mem_req == 1'b0, "R2", "mem_req after reset", mem_req, 0);

        cfg_write_back = 1; cfg_write_alloc = 1; cfg_load_through = 1;
        run_op(0, mk(1, 2, 0), 0, 0, 0);           // R5 early word 0
        run_op(0, mk(1, 2, 0), 0, 0, 0);           // R3 hit
        run_op(0, mk(1, 3, 31), 0, 0, 0);          // R5 last word: no gain
        cfg_load_through = 0;
        run_op(0, mk(1, 4, 5), 0, 0, 0);           // R5 disabled
        run_op(1, mk(1, 2, 7), 32'hCAFE_0007, 0, 0); // R9 write-back hit
        run_op(0, mk(2, 2, 1), 0, 0, 0);           // R6 invalid way first
        run_op(0, mk(3, 2, 0), 0, 0, 0);           // R7 dirty victim by LRU
        run_op(0, mk(1, 2, 7), 0, 0, 0);           // R7 written-back data returns
        cfg_write_back = 0;
        run_op(1, mk(1, 2, 3), 32'hBEEF_0003, 0, 0); // R8 write-through hit
        cfg_write_alloc = 0;
        run_op(1, mk(0, 5, 9), 32'h1234_0009, 0, 0); // R10 no-allocate
        run_op(0, mk(0, 5, 9), 0, 0, 0);           // R10 later read misses
        cfg_write_alloc = 1; cfg_write_back = 1;
        run_op(1, mk(0, 6, 2), 32'h0600_0002, 0, 0); // R10 allocate
        do_cmd(1, mk(0, 6, 0));                    // R11 pin line
        run_op(1, mk(0, 6, 4), 32'h0600_0004, 0, 0); // R11 write goes through
        run_op(1, mk(1, 2, 8), 32'hD1D1_0008, 0, 0);
        do_cmd(0, mk(1, 2, 0));                    // R12 invalidate dirty line
        run_op(0, mk(1, 2, 8), 0, 0, 0);           // R12 misses, old memory value
        do_cmd(0, mk(2, 9, 0));                    // R12 no matching line
        cfg_load_through = 1;
        run_op(0, mk(1, 3, 0), 0, 1, 0);           // R13 command with request

        for (int i = 0; i < 1200; i++) begin
            if (i % 100 == 0) begin
                cfg_write_back   = $urandom % 2;
                cfg_write_alloc  = $urandom % 2;
                cfg_load_through = $urandom % 2;
            end
            a = mk($urandom % 3, $urandom % 4, $urandom % 32);
            if (($urandom % 20) == 0) do_cmd($urandom % 2, a);
            else run_op($urandom % 2, a, $urandom, 0, 0);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule